// File: doc/BRIEF.md
# Deferred Software Interrupt Arbiter

This block collects software interrupt requests and hands them out one at a time to a single handler engine. Each request carries an ID and one of five priority classes. A request waits in a short first-in, first-out queue for its class. It is released only when no hardware interrupt is in progress, no software interrupt is already running, and the global disable nest count is zero. Among the waiting requests, the block always releases the head of the highest non-empty class.

The block issues a one-cycle start pulse with the selected ID and raises a busy flag. It holds that ID until the handler returns a done strobe. Requests for an ID that is running are dropped. Requests for an ID that is already waiting are merged into the waiting entry. Disable and enable strobes move a bounded nest counter. A misuse of that counter sets a sticky error flag.

Top module: `swirq_arbiter`

## Requirements
- R1: The priority class code on `causePri` is 0 to 4, standing for levels -32, -16, 0, +16 and +32. A cause with code 5, 6 or 7 is ignored.
- R2: When a request is released, it comes from the highest non-empty class (code 4 highest).
- R3: Within one class, requests are released in the order they were accepted.
- R4: Nothing is released in a cycle where `hwActive` is high. Waiting requests are held until it is low.
- R5: A release happens on the clock edge that ends a cycle in which busy is low and a request is waiting. On that edge `runReq` pulses high for one cycle and `busy` goes high with `runId` set. `runId` and `busy` then hold until a `doneStrobe` edge clears busy. Releases never overlap.
- R6: A cause whose ID equals the running `runId` while busy is high is ignored.
- R7: A cause whose ID is already waiting is merged, so that ID is released only once.
- R8: Each class holds `QUEUE_DEPTH` IDs (default 4). A cause to a full class is dropped.
- R9: Each `disableStrobe` raises the nest count and each `enableStrobe` lowers it. Requests are released only while the count is zero.
- R10: The count saturates at 126. A disable at 126, or an enable at 0, leaves the count unchanged and sets `disErr`, which stays set until reset.
- R11: A disable and an enable in the same cycle leave the count unchanged and raise no error.
- R12: A `doneStrobe` while busy is low has no effect.
- R13: After reset, busy, `runReq` and `disErr` are low, every queue is empty and the nest count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| causeValid | input | 1 | Cause request strobe |
| causeId | input | ID_W | ID of the requested software interrupt |
| causePri | input | 3 | Priority class code, 0 (lowest) to 4 (highest) |
| hwActive | input | 1 | High while any hardware interrupt is in progress |
| doneStrobe | input | 1 | Running handler has finished |
| disableStrobe | input | 1 | Enter one disable level |
| enableStrobe | input | 1 | Leave one disable level |
| runReq | output | 1 | One-cycle pulse when an ID is released |
| runId | output | ID_W | ID of the released or running interrupt |
| busy | output | 1 | A software interrupt is running |
| disErr | output | 1 | Sticky nest-counter misuse flag |

## Verification
The hardest state to reach is the saturation edge of the nest counter. It takes 126 consecutive disables before the 127th can be rejected, and then 126 enables before releasing is allowed again. The stimulus holds the disable strobe for 127 cycles and checks the error flag between the last accepted disable and the rejected one. It then holds the enable strobe for 126 cycles and confirms that a waiting request is released afterwards. Merge and drop rules need a request to arrive while the same ID is waiting or running. The stimulus gets there by holding `hwActive` high to fill the queues, and by withholding `doneStrobe` while it re-issues a running ID.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int NUM_CLASSES = 5;
  localparam int CLS_W = 3;

  typedef struct packed {
    logic             push;
    logic [CLS_W-1:0] pushCls;
    logic             pop;
    logic [CLS_W-1:0] popCls;
    logic             clearRun;
  } swirq_ctl_t;
endpackage

// File: rtl/swirq_datapath.sv
module swirq_datapath
  import swirq_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  swirq_ctl_t             ctl,
  input  logic [ID_W-1:0]        causeId,
  output logic [NUM_CLASSES-1:0] clsNotEmpty,
  output logic [NUM_CLASSES-1:0] clsFull,
  output logic                   idPending,
  output logic                   idRunning,
  output logic                   busy,
  output logic                   runReq,
  output logic [ID_W-1:0]        runId
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int PTR_W   = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W   = $clog2(QUEUE_DEPTH + 1);

  logic [ID_W-1:0]    headId [NUM_CLASSES];
  logic [ID_W-1:0]    popId;
  logic [NUM_IDS-1:0] pendQ;
  logic               busyQ;
  logic               runReqQ;
  logic [ID_W-1:0]    runIdQ;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [ID_W-1:0]  mem [QUEUE_DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] fill;
    logic             doPush, doPop;

    assign doPush = ctl.push && (ctl.pushCls == CLS_W'(c));
    assign doPop  = ctl.pop  && (ctl.popCls  == CLS_W'(c));
    assign clsNotEmpty[c] = (fill != '0);
    assign clsFull[c]     = (fill == CNT_W'(QUEUE_DEPTH));
    assign headId[c]      = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= causeId;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill  <= '0;
      end else begin
        if (doPush) wrPtr <= (wrPtr == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (doPop)  rdPtr <= (rdPtr == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (doPush && !doPop)      fill <= fill + 1'b1;
        else if (doPop && !doPush) fill <= fill - 1'b1;
      end
    end
  end

  always_comb begin
    popId = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (ctl.popCls == CLS_W'(c)) popId = headId[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      busyQ   <= 1'b0;
      runReqQ <= 1'b0;
      runIdQ  <= '0;
    end else begin
      if (ctl.push) pendQ[causeId] <= 1'b1;
      if (ctl.pop)  pendQ[popId]   <= 1'b0;
      runReqQ <= ctl.pop;
      if (ctl.pop) begin
        busyQ  <= 1'b1;
        runIdQ <= popId;
      end else if (ctl.clearRun) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign idPending = pendQ[causeId];
  assign idRunning = busyQ && (runIdQ == causeId);
  assign busy      = busyQ;
  assign runReq    = runReqQ;
  assign runId     = runIdQ;

  AST_POP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !busyQ); // R5
  AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !ctl.clearRun) |=> (busyQ && $stable(runIdQ))); // R5
  AST_TOP_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> ((clsNotEmpty >> ctl.popCls) == NUM_CLASSES'(1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> ((clsFull >> ctl.pushCls) & NUM_CLASSES'(1)) == '0); // R8
  AST_PUSH_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> !pendQ[causeId]); // R7
  AST_RUN_NOT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !pendQ[runIdQ]); // R6
endmodule

// File: rtl/swirq_control.sv
module swirq_control
  import swirq_pkg::*;
#(
  parameter int MAX_NEST = 126
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   causeValid,
  input  logic [CLS_W-1:0]       causePri,
  input  logic                   hwActive,
  input  logic                   doneStrobe,
  input  logic                   disableStrobe,
  input  logic                   enableStrobe,
  input  logic [NUM_CLASSES-1:0] clsNotEmpty,
  input  logic [NUM_CLASSES-1:0] clsFull,
  input  logic                   idPending,
  input  logic                   idRunning,
  input  logic                   busy,
  output swirq_ctl_t             ctl,
  output logic                   disErr
);
  localparam int NEST_W = $clog2(MAX_NEST + 1);

  logic [NEST_W-1:0] nestQ;
  logic              errQ;
  logic              clsValid;
  logic              fullSel;
  logic [CLS_W-1:0]  topCls;

  assign clsValid = (causePri < CLS_W'(NUM_CLASSES));

  always_comb begin
    fullSel = 1'b0;
    topCls  = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (causePri == CLS_W'(c)) fullSel = clsFull[c];
      if (clsNotEmpty[c])        topCls  = CLS_W'(c);
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.push     = causeValid && clsValid && !idPending && !idRunning && !fullSel;
    ctl.pushCls  = causePri;
    ctl.pop      = !busy && !hwActive && (nestQ == '0) && (|clsNotEmpty);
    ctl.popCls   = topCls;
    ctl.clearRun = busy && doneStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nestQ <= '0;
      errQ  <= 1'b0;
    end else if (disableStrobe && !enableStrobe) begin
      if (nestQ == NEST_W'(MAX_NEST)) errQ <= 1'b1;
      else                            nestQ <= nestQ + 1'b1;
    end else if (enableStrobe && !disableStrobe) begin
      if (nestQ == '0) errQ <= 1'b1;
      else             nestQ <= nestQ - 1'b1;
    end
  end

  assign disErr = errQ;

  AST_NEST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    nestQ <= NEST_W'(MAX_NEST)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ); // R10
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (disableStrobe && !enableStrobe && nestQ == NEST_W'(MAX_NEST)) |=> ($stable(nestQ) && errQ)); // R10
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (disableStrobe && enableStrobe) |=> $stable(nestQ)); // R11
endmodule

// File: rtl/swirq_arbiter.sv
module swirq_arbiter
  import swirq_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int MAX_NEST    = 126
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             causeValid,
  input  logic [ID_W-1:0]  causeId,
  input  logic [2:0]       causePri,
  input  logic             hwActive,
  input  logic             doneStrobe,
  input  logic             disableStrobe,
  input  logic             enableStrobe,
  output logic             runReq,
  output logic [ID_W-1:0]  runId,
  output logic             busy,
  output logic             disErr
);
  swirq_ctl_t             ctl;
  logic [NUM_CLASSES-1:0] clsNotEmpty;
  logic [NUM_CLASSES-1:0] clsFull;
  logic                   idPending;
  logic                   idRunning;

  swirq_control #(.MAX_NEST(MAX_NEST)) i_control (
    .clk(clk), .rstN(rstN), .causeValid(causeValid), .causePri(causePri),
    .hwActive(hwActive), .doneStrobe(doneStrobe), .disableStrobe(disableStrobe),
    .enableStrobe(enableStrobe), .clsNotEmpty(clsNotEmpty), .clsFull(clsFull),
    .idPending(idPending), .idRunning(idRunning), .busy(busy), .ctl(ctl),
    .disErr(disErr)
  );

  swirq_datapath #(.ID_W(ID_W), .QUEUE_DEPTH(QUEUE_DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .causeId(causeId),
    .clsNotEmpty(clsNotEmpty), .clsFull(clsFull), .idPending(idPending),
    .idRunning(idRunning), .busy(busy), .runReq(runReq), .runId(runId)
  );

  AST_DEFER_HW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!hwActive)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    runReq |=> !runReq); // R5
endmodule

// File: tb/test_swirq_arbiter.sv
`timescale 1ns/1ps
module test_swirq_arbiter;
  localparam int ID_W = 4;
  localparam int DEPTH = 4;
  localparam int MAXN = 126;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic causeValid = 1'b0;
  logic [ID_W-1:0] causeId = '0;
  logic [2:0] causePri = '0;
  logic hwActive = 1'b0, doneStrobe = 1'b0, disableStrobe = 1'b0, enableStrobe = 1'b0;
  logic runReq, busy, disErr;
  logic [ID_W-1:0] runId;

  swirq_arbiter i_swirq_arbiter (
    .clk(clk), .rstN(rstN), .causeValid(causeValid), .causeId(causeId),
    .causePri(causePri), .hwActive(hwActive), .doneStrobe(doneStrobe),
    .disableStrobe(disableStrobe), .enableStrobe(enableStrobe),
    .runReq(runReq), .runId(runId), .busy(busy), .disErr(disErr)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string curReq = "R13";

  // behavioural reference model
  int mq [5][$];
  bit mPend [16];
  bit mBusy, mReq, mErr;
  int mRun, mNest;
  int seen [$];

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 5; c++) mq[c].delete();
      for (int i = 0; i < 16; i++) mPend[i] = 0;
      mBusy = 0; mReq = 0; mErr = 0; mRun = 0; mNest = 0;
    end else begin
      bit doPush, doPop;
      int pc, id;
      pc = int'(causePri);
      id = int'(causeId);
      doPush = causeValid && pc < 5 && !(mBusy && mRun == id) && !mPend[id]
               && (pc < 5 ? mq[pc].size() < DEPTH : 0);
      doPop = !mBusy && !hwActive && mNest == 0;
      if (doPop) begin
        doPop = 0;
        for (int c = 4; c >= 0; c--)
          if (!doPop && mq[c].size() > 0) begin
            doPop = 1;
            mRun = mq[c].pop_front();
            mPend[mRun] = 0;
          end
      end
      mReq = doPop;
      if (doPop) mBusy = 1;
      else if (mBusy && doneStrobe) mBusy = 0;
      if (doPush) begin
        mq[pc].push_back(id);
        mPend[id] = 1;
      end
      if (disableStrobe && !enableStrobe) begin
        if (mNest == MAXN) mErr = 1; else mNest++;
      end else if (enableStrobe && !disableStrobe) begin
        if (mNest == 0) mErr = 1; else mNest--;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "busy", int'(busy), int'(mBusy));
      chk(curReq, "runReq", int'(runReq), int'(mReq));
      chk(curReq, "disErr", int'(disErr), int'(mErr));
      if (mBusy) chk(curReq, "runId", int'(runId), mRun);
      if (runReq) seen.push_back(int'(runId));
    end
  end

  task automatic cause(int id, int pri);
    causeValid = 1'b1; causeId = ID_W'(id); causePri = 3'(pri);
    @(negedge clk);
    causeValid = 1'b0;
  endtask

  task automatic drain(int n);
    repeat (n) begin
      @(negedge clk);
      doneStrobe = busy;
    end
    doneStrobe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectSeen(string req, int e[$]);
    chk(req, "release count", seen.size(), e.size());
    for (int i = 0; i < e.size() && i < seen.size(); i++)
      chk(req, "release order", seen[i], e[i]);
    seen.delete();
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    chk("R13", "busy after reset", int'(busy), 0);
    chk("R13", "runReq after reset", int'(runReq), 0);
    chk("R13", "disErr after reset", int'(disErr), 0);

    // R1, R2, R4: classes, priority, hardware deferral
    curReq = "R4";
    hwActive = 1'b1;
    cause(1, 0); cause(2, 4); cause(3, 2); cause(4, 6);
    idle(4);
    chk("R4", "held while hw active", int'(busy), 0);
    hwActive = 1'b0;
    curReq = "R2";
    drain(14);
    expectSeen("R2", '{2, 3, 1});
    chk("R1", "invalid class ignored", int'(busy), 0);

    // R3: arrival order within a class
    curReq = "R3";
    hwActive = 1'b1;
    cause(5, 1); cause(6, 1); cause(7, 1);
    hwActive = 1'b0;
    drain(12);
    expectSeen("R3", '{5, 6, 7});

    // R6, R7: running drop, pending merge
    curReq = "R7";
    hwActive = 1'b1;
    cause(8, 3); cause(8, 3); cause(9, 0);
    hwActive = 1'b0;
    idle(1);
    chk("R5", "released id", int'(runId), 8);
    curReq = "R6";
    cause(8, 3);
    chk("R6", "still running", int'(busy), 1);
    drain(12);
    expectSeen("R6", '{8, 9});

    // R8: full class drops
    curReq = "R8";
    hwActive = 1'b1;
    for (int i = 10; i < 15; i++) cause(i, 2);
    hwActive = 1'b0;
    drain(16);
    expectSeen("R8", '{10, 11, 12, 13});

    // R9, R11: nesting and simultaneous strobes
    curReq = "R9";
    disableStrobe = 1'b1; idle(2); disableStrobe = 1'b0;
    cause(1, 4);
    idle(3);
    chk("R9", "held at nest 2", int'(busy), 0);
    enableStrobe = 1'b1; idle(1); enableStrobe = 1'b0;
    idle(3);
    chk("R9", "held at nest 1", int'(busy), 0);
    curReq = "R11";
    disableStrobe = 1'b1; enableStrobe = 1'b1; idle(1);
    disableStrobe = 1'b0; enableStrobe = 1'b0;
    idle(2);
    chk("R11", "still held", int'(busy), 0);
    chk("R11", "no error", int'(disErr), 0);
    enableStrobe = 1'b1; idle(1); enableStrobe = 1'b0;
    curReq = "R9";
    drain(6);
    expectSeen("R9", '{1});

    // R10: saturation at 126
    curReq = "R10";
    disableStrobe = 1'b1;
    idle(MAXN);
    chk("R10", "no error at limit", int'(disErr), 0);
    idle(1);
    disableStrobe = 1'b0;
    chk("R10", "error past limit", int'(disErr), 1);
    cause(2, 0);
    enableStrobe = 1'b1;
    idle(MAXN - 1);
    chk("R10", "held at nest 1", int'(busy), 0);
    idle(1);
    enableStrobe = 1'b0;
    drain(6);
    expectSeen("R10", '{2});
    chk("R10", "error sticky", int'(disErr), 1);

    // R12 and enable at zero
    rstN = 1'b0; idle(2); rstN = 1'b1;
    curReq = "R12";
    doneStrobe = 1'b1; idle(1); doneStrobe = 1'b0;
    idle(1);
    chk("R12", "done while idle", int'(busy), 0);
    chk("R12", "no error from done", int'(disErr), 0);
    curReq = "R10";
    enableStrobe = 1'b1; idle(1); enableStrobe = 1'b0;
    idle(1);
    chk("R10", "enable at zero error", int'(disErr), 1);
    idle(2);
    finish();
  end
endmodule